// File: doc/BRIEF.md
# Grouped Edge-Sense Wake Controller

This block watches a set of asynchronous wake-up inputs, organised in banks of eight lines, and latches an edge event on any line into a sticky status bit. Each line's status bit is also driven straight out as that line's interrupt request, so a sleeping processor or an interrupt router can see which line woke it.

Each bank has three byte registers reached over a simple byte-addressed write/read bus:
- a polarity register, where 1 selects the falling edge and 0 selects the rising edge;
- a dual-edge register, where 1 makes any transition count;
- a status register, which software clears by writing 1 to a bit.

The registers of the first four banks sit at consecutive addresses. Later banks are spaced four bytes apart. Only edges are sensed; a held level never sets a status bit.

Top module: `wake_edge_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every polarity, dual-edge and status bit reads 0 and every irq_out bit is 0.
- R2: With polarity bit 0 and dual-edge bit 0, a 0-to-1 change on the line sets its status bit, and a 1-to-0 change does not.
- R3: With polarity bit 1 and dual-edge bit 0, a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R4: With the dual-edge bit at 1, either transition sets the status bit, whatever the polarity bit holds.
- R5: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R6: Bank g (numbered from 1) uses a byte offset of g-1 for g up to 4, and 4*(g-4) for g of 5 and above. That offset is added to a per-register base: polarity at 0x00, dual-edge at 0x40, status at 0x80. Reads of unmapped addresses return 0, and writes to them change nothing.
- R7: If an edge is detected in the same cycle as a write of 1 to that status bit, the bit stays set.
- R8: irq_out bit 8*(g-1)+b always equals status bit b of bank g.
- R9: A set status bit stays set after its line returns to its old level, until it is cleared or the block is reset.
- R10: Writing the polarity or dual-edge registers does not change any status bit, and a status bit can be cleared in the cycle right after such a write.
- R11: A line change is seen through a two-flop synchronizer. The status bit is set at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 8*NUM_BANKS | Asynchronous wake lines, bank-major |
| bus_wr | input | 1 | Write strobe for one byte register |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_out | output | 8*NUM_BANKS | Per-line interrupt request |

## Verification
The hardest case to reach from the ports is an edge that lands in the very cycle a clear write hits the same bit. The line must change exactly two cycles before the write strobe, so that the synchronizer output and the clear meet at one clock edge. A directed sequence counts negative edges from the line change to place the write there. Random rounds mix configuration writes, line toggles and partial clears across all banks. Each round is checked against a bench model that computes every bank's expected status.

// File: rtl/wake_edge_pkg.sv
// Package: shared constants and the bank address layout function.
// Assumes banks are numbered from 0 internally (bank 0 is the first bank).
package wake_edge_pkg;

    localparam int unsigned LINES_PER_BANK = 8;
    localparam int unsigned EARLY_BANKS    = 4;
    localparam int unsigned LATE_STRIDE    = 4;

    // Byte offset of internal bank index k inside one register kind's window.
    function automatic int unsigned bank_offset(input int unsigned k);
        if (k < EARLY_BANKS) begin
            return k;
        end
        return LATE_STRIDE * (k - (EARLY_BANKS - 1));
    endfunction

endpackage

// File: rtl/wake_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous lines.
// Assumes each bit is independent; no bus coherence is implied.
module wake_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the line values one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wake_addr_decode.sv
// Module: turns a byte address into one-hot bank selects per register kind.
// Assumes the three register windows do not overlap (checked by assertion).
module wake_addr_decode
    import wake_edge_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned POL_BASE  = 'h00,
    parameter int unsigned DUAL_BASE = 'h40,
    parameter int unsigned STAT_BASE = 'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_BANKS-1:0] pol_sel_o,
    output logic [NUM_BANKS-1:0] dual_sel_o,
    output logic [NUM_BANKS-1:0] stat_sel_o
);
    genvar k;
    generate
        for (k = 0; k < NUM_BANKS; k++) begin : g_bank
            localparam int unsigned OFS = bank_offset(k);
            // Purpose: compare the address against this bank's three registers.
            always_comb begin
                pol_sel_o[k]  = (addr_i == ADDR_W'(POL_BASE  + OFS));
                dual_sel_o[k] = (addr_i == ADDR_W'(DUAL_BASE + OFS));
                stat_sel_o[k] = (addr_i == ADDR_W'(STAT_BASE + OFS));
            end
        end
    endgenerate

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pol_sel_o, dual_sel_o, stat_sel_o})); // R6
endmodule

// File: rtl/wake_bank.sv
// Module: one bank of eight wake lines with polarity, dual-edge and
// write-1-to-clear status registers. Assumes writes are one-cycle strobes.
module wake_bank
    import wake_edge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LINES_PER_BANK-1:0] line_i,
    input  logic                      pol_wr_i,
    input  logic                      dual_wr_i,
    input  logic                      stat_wr_i,
    input  logic [LINES_PER_BANK-1:0] wdata_i,
    output logic [LINES_PER_BANK-1:0] pol_o,
    output logic [LINES_PER_BANK-1:0] dual_o,
    output logic [LINES_PER_BANK-1:0] stat_o
);
    localparam int unsigned W = LINES_PER_BANK;

    logic [W-1:0] sync_s, prev_q, rise_s, fall_s, hit_s, clr_s;
    logic [W-1:0] pol_q, dual_q, stat_q;

    wake_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (sync_s)
    );

    // Purpose: hold last cycle's synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_s;
    end

    // Purpose: classify transitions and select the ones this bank wants.
    always_comb begin
        rise_s = sync_s & ~prev_q;
        fall_s = ~sync_s & prev_q;
        hit_s  = (rise_s & (~pol_q | dual_q)) | (fall_s & (pol_q | dual_q));
        clr_s  = stat_wr_i ? wdata_i : '0;
    end

    // Purpose: software-written edge configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            dual_q <= '0;
        end else begin
            if (pol_wr_i)  pol_q  <= wdata_i;
            if (dual_wr_i) dual_q <= wdata_i;
        end
    end

    // Purpose: sticky status, new edges take priority over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_s) | hit_s;
    end

    assign pol_o  = pol_q;
    assign dual_o = dual_q;
    assign stat_o = stat_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_q) & ~$past(clr_s)) & ~stat_q) == '0)); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(hit_s)) == $past(hit_s))); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(clr_s) & ~$past(hit_s)) == '0)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat_q & ~$past(stat_q)) & ~$past(hit_s)) == '0)); // R10
    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_s & ~pol_q & ~dual_q & fall_s) == '0)); // R2
endmodule

// File: rtl/wake_edge_ctrl.sv
// Module: top of the grouped wake edge controller. Instantiates one bank per
// group, the address decoder and the read-back mux. Assumes a single-cycle
// write strobe and a combinational read of the addressed register.
module wake_edge_ctrl
    import wake_edge_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned POL_BASE    = 'h00,
    parameter int unsigned DUAL_BASE   = 'h40,
    parameter int unsigned STAT_BASE   = 'h80
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] line_in,
    input  logic                                bus_wr,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [7:0]                          bus_wdata,
    output logic [7:0]                          bus_rdata,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_out
);
    localparam int unsigned W = LINES_PER_BANK;

    logic [NUM_BANKS-1:0] pol_sel, dual_sel, stat_sel;
    logic [W-1:0]         pol_v  [NUM_BANKS];
    logic [W-1:0]         dual_v [NUM_BANKS];
    logic [W-1:0]         stat_v [NUM_BANKS];

    wake_addr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .POL_BASE  (POL_BASE),
        .DUAL_BASE (DUAL_BASE),
        .STAT_BASE (STAT_BASE)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .pol_sel_o  (pol_sel),
        .dual_sel_o (dual_sel),
        .stat_sel_o (stat_sel)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_BANKS; k++) begin : g_bank
            wake_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .line_i    (line_in[k*W +: W]),
                .pol_wr_i  (bus_wr & pol_sel[k]),
                .dual_wr_i (bus_wr & dual_sel[k]),
                .stat_wr_i (bus_wr & stat_sel[k]),
                .wdata_i   (bus_wdata),
                .pol_o     (pol_v[k]),
                .dual_o    (dual_v[k]),
                .stat_o    (stat_v[k])
            );
            assign irq_out[k*W +: W] = stat_v[k];
        end
    endgenerate

    // Purpose: OR together the selected register; unmapped addresses give 0.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            bus_rdata |= ({W{pol_sel[i]}}  & pol_v[i])
                       | ({W{dual_sel[i]}} & dual_v[i])
                       | ({W{stat_sel[i]}} & stat_v[i]);
        end
    end

    AST_IRQ_QUIET_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0)); // R1
    AST_READ_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((pol_sel | dual_sel | stat_sel) == '0) |-> (bus_rdata == 8'h00)); // R6
endmodule

// File: tb/wake_edge_ctrl_tb_top.sv
// Bench: directed corner cases plus seeded random rounds against a model.
module wake_edge_ctrl_tb_top;
    localparam int NB = 8;
    localparam int NL = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] line_in = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'hFF;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NL-1:0] irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] m_pol  [NB];
    logic [7:0] m_dual [NB];
    logic [7:0] m_stat [NB];

    always #2.5 clk = ~clk;

    wake_edge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // g numbered from 1; base 0x00 polarity, 0x40 dual, 0x80 status
    function automatic logic [7:0] addr_of(input int base, input int g);
        return 8'(base + ((g <= 4) ? (g - 1) : 4 * (g - 4)));
    endfunction

    function automatic logic [7:0] exp_hits(input logic [7:0] o, input logic [7:0] n,
                                            input logic [7:0] p, input logic [7:0] d);
        logic [7:0] r;
        logic [7:0] f;
        r = n & ~o;
        f = o & ~n;
        return (r & ((~p) | d)) | (f & (p | d));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'hFF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'hFF;
    endtask

    task automatic set_cfg(input int g, input logic [7:0] p, input logic [7:0] d);
        wr(addr_of('h00, g), p); m_pol[g-1] = p;
        wr(addr_of('h40, g), d); m_dual[g-1] = d;
    endtask

    task automatic apply_lines(input logic [NL-1:0] nv);
        for (int k = 0; k < NB; k++)
            m_stat[k] |= exp_hits(line_in[k*8 +: 8], nv[k*8 +: 8], m_pol[k], m_dual[k]);
        line_in = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int g = 1; g <= NB; g++) begin
            rd(addr_of('h80, g), v);
            check(v == m_stat[g-1], req, v, m_stat[g-1]);
            check(irq_out[(g-1)*8 +: 8] == m_stat[g-1], "R8", irq_out[(g-1)*8 +: 8], m_stat[g-1]);
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED1234));
        for (int k = 0; k < NB; k++) begin m_pol[k] = '0; m_dual[k] = '0; m_stat[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int g = 1; g <= NB; g++) begin
            rd(addr_of('h00, g), v); check(v == 0, "R1 polarity", v, 0);
            rd(addr_of('h40, g), v); check(v == 0, "R1 dual", v, 0);
        end
        check(irq_out == '0, "R1 irq", 0, 0);
        check_all("R1");

        // R6: unique address per bank, readback of polarity
        for (int g = 1; g <= NB; g++) wr(addr_of('h00, g), 8'(g * 17));
        for (int g = 1; g <= NB; g++) begin
            rd(addr_of('h00, g), v); check(v == 8'(g * 17), "R6 layout", v, g * 17);
        end
        wr(8'h03 + 8'h01 + 8'h01, 8'hAA); // 0x05 unmapped
        rd(8'h05, v); check(v == 0, "R6 unmapped read", v, 0);
        rd(addr_of('h00, 5), v); check(v == 8'(5 * 17), "R6 unmapped write", v, 5 * 17);
        for (int g = 1; g <= NB; g++) set_cfg(g, 8'h00, 8'h00);

        // R2 / R11: rising sets at third edge; falling does not
        line_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        check(irq_out[0] == 1'b0, "R11 not before third edge", irq_out[0], 0);
        @(negedge clk);
        check(irq_out[0] == 1'b1, "R11 set at third edge", irq_out[0], 1);
        m_stat[0][0] = 1'b1;
        wr(addr_of('h80, 1), 8'h01); m_stat[0][0] = 1'b0;
        apply_lines(line_in & ~NL'(1));
        check_all("R2 falling ignored");

        // R3: falling only when polarity=1
        set_cfg(2, 8'hFF, 8'h00);
        apply_lines(line_in | (NL'(8'h0F) << 8));
        check_all("R3 rising ignored");
        apply_lines(line_in & ~(NL'(8'h05) << 8));
        check_all("R3 falling sets");

        // R9: sticky after line returns
        apply_lines(line_in | (NL'(8'h05) << 8));
        check_all("R9 sticky");

        // R5: write 0 keeps, write 1 clears
        wr(addr_of('h80, 2), 8'h00);
        check_all("R5 write zero");
        wr(addr_of('h80, 2), 8'h04); m_stat[1] &= ~8'h04;
        check_all("R5 write one");

        // R4: dual edge regardless of polarity
        set_cfg(6, 8'hF0, 8'hFF);
        apply_lines(line_in | (NL'(8'h81) << 40));
        check_all("R4 rise");
        wr(addr_of('h80, 6), 8'hFF); m_stat[5] = '0;
        apply_lines(line_in & ~(NL'(8'h81) << 40));
        check_all("R4 fall");

        // R10: config change leaves status, clear right after works
        set_cfg(6, 8'h0F, 8'h00);
        check_all("R10 config no effect");
        wr(addr_of('h80, 6), 8'hFF); m_stat[5] = '0;
        check_all("R10 clear after config");

        // R7: edge meets clear in the same cycle
        set_cfg(8, 8'h00, 8'h00);
        wr(addr_of('h80, 8), 8'hFF); m_stat[7] = '0;
        line_in[56] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_addr = addr_of('h80, 8); bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'hFF;
        m_stat[7][0] = 1'b1;
        check_all("R7 set wins");

        // random rounds
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            if (op == 0) begin
                int g;
                g = int'($urandom_range(1, NB));
                set_cfg(g, 8'($urandom), 8'($urandom));
            end else if (op == 1) begin
                int g;
                logic [7:0] m;
                g = int'($urandom_range(1, NB));
                m = 8'($urandom);
                wr(addr_of('h80, g), m); m_stat[g-1] &= ~m;
            end else begin
                logic [NL-1:0] nv;
                nv = {$urandom, $urandom};
                apply_lines(nv);
            end
            if ((it % 10) == 9) check_all("R4 random");
        end
        check_all("R5 random final");

        // R1: reset clears status again
        rst_n = 1'b0;
        @(negedge clk);
        line_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NB; k++) begin m_pol[k] = '0; m_dual[k] = '0; m_stat[k] = '0; end
        check_all("R1 second reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule